// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Request/Grant

This block copies a run of 32-bit words between an I/O device and main memory so the processor does not have to. Software first writes three values while the engine is idle: the starting memory address, the number of words, and a command. The command picks the direction (device into memory, or memory out to the device), picks the transfer mode, and starts the run.

Before it touches memory, the engine raises a bus request and waits for the processor to answer with a bus grant. Two modes are supported. In burst mode the engine keeps the bus until the whole block has moved. In stealing mode it gives the bus back after every word. It then asks for the bus again, but only once it has seen the grant drop. Words enter and leave the device side through valid/ready handshakes. Memory cycles use a valid/ready pair with a write-enable.

For each word it moves, the engine steps the address forward by four bytes and lowers the count by one. When the count reaches zero it releases the bus, sets a sticky done flag and pulses an interrupt for one cycle.

Top module: `xfer_dma`

## Requirements
- R1: After reset, busy, done, irq, bus_req, mem_valid, dev_in_ready and dev_out_valid are all 0, and cur_addr and cur_count are 0.
- R2: While idle, a cfg_we cycle stores cfg_wdata into the register picked by cfg_sel: 0 is the address, 1 is the word count (low 16 bits) and 2 is the command. The command fields are bit 0 for direction (0 = device to memory, 1 = memory to device), bit 1 for mode (0 = burst, 1 = stealing) and bit 2 for go. cur_addr and cur_count show the stored values on the next cycle. A command write with go clear does not start a transfer.
- R3: bus_req is raised before any memory or device cycle. mem_valid and dev_in_ready are asserted only while bus_gnt is high.
- R4: In device-to-memory direction, the words accepted on dev_in_data are written to memory in arrival order, at addresses start, start+4, start+8 and so on.
- R5: In memory-to-device direction, the word read at each of the consecutive addresses is presented on dev_out_data, in address order.
- R6: In burst mode, bus_req rises exactly once per transfer. It stays high through memory and device stalls until the last word.
- R7: In stealing mode, bus_req drops after each word and rises once per word. It is never raised again while bus_gnt is still high.
- R8: Each completed word adds 4 to cur_addr and subtracts 1 from cur_count. The address wraps modulo 2^32.
- R9: On completion of the last word, bus_req drops, done goes to 1 and irq is high for exactly one cycle. Starting a new transfer clears done.
- R10: A start with a word count of 0 sets done and pulses irq on the next cycle without raising bus_req.
- R11: While busy, register writes of any kind are ignored. The transfer in flight keeps its direction, addresses and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 command |
| cfg_wdata | input | 32 | Register write data |
| cur_addr | output | 32 | Current memory address |
| cur_count | output | 16 | Words still to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_valid | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory cycle completes |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Engine accepts a device word |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device accepts the word |

## Verification
The bench's bus arbiter grants the bus only after a delay and holds the grant for two cycles after the request drops. This exposes an engine that re-requests while the grant is still high in stealing mode, or that starts a memory cycle before it has been granted. Memory and device stalls are injected during burst runs, so an engine that releases the bus while stalled shows more than one request edge. A zero-length start must finish with no request edge at all; a design that always requests would hang on the bus or make a phantom memory access. A run that begins just below the top of the address space checks the wrap. Command and address writes made in mid-transfer must leave the scoreboard's expected addresses, data order and final counts unchanged.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CMD   = 2'd2
  } reg_sel_e;

  typedef enum logic {
    DIR_DEV2MEM = 1'b0,
    DIR_MEM2DEV = 1'b1
  } dir_e;

  typedef enum logic {
    MODE_BURST = 1'b0,
    MODE_STEAL = 1'b1
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK,
    ST_FETCH,
    ST_STORE,
    ST_YIELD
  } state_e;

  localparam int CMD_DIR_BIT  = 0;
  localparam int CMD_MODE_BIT = 1;
  localparam int CMD_GO_BIT   = 2;
endpackage

// File: rtl/xfer_dma_regs.sv
module xfer_dma_regs
  import xfer_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          word_done,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output dir_e          dir_q,
  output mode_e         mode_q,
  output logic          start
);
  localparam logic [AW-1:0] ADDR_STEP = AW'(WORD_BYTES);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + ADDR_STEP;
  endfunction

  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  logic wr_ok, wr_addr, wr_count, wr_cmd;
  assign wr_ok    = cfg_we && !busy;
  assign wr_addr  = wr_ok && (cfg_sel == SEL_ADDR);
  assign wr_count = wr_ok && (cfg_sel == SEL_COUNT);
  assign wr_cmd   = wr_ok && (cfg_sel == SEL_CMD);
  assign start    = wr_cmd && cfg_wdata[CMD_GO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= DIR_DEV2MEM;
      mode_q  <= MODE_BURST;
    end else begin
      if (wr_addr)        addr_q <= cfg_wdata[AW-1:0];
      else if (word_done) addr_q <= step_addr(addr_q);
      if (wr_count)       count_q <= cfg_wdata[CW-1:0];
      else if (word_done) count_q <= step_count(count_q);
      if (wr_cmd) begin
        dir_q  <= dir_e'(cfg_wdata[CMD_DIR_BIT]);
        mode_q <= mode_e'(cfg_wdata[CMD_MODE_BIT]);
      end
    end
  end

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (count_q == $past(count_q) - CW'(1)) && (addr_q == $past(addr_q) + ADDR_STEP));

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy && !word_done) |=> (addr_q == $past(addr_q)) && (count_q == $past(count_q))
                                        && (dir_q == $past(dir_q)) && (mode_q == $past(mode_q)));
endmodule

// File: rtl/xfer_dma_seq.sv
module xfer_dma_seq
  import xfer_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          zero_len,
  input  logic          last_word,
  input  dir_e          dir,
  input  mode_e         mode,
  input  logic          bus_gnt,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_out_ready,
  output logic          busy,
  output logic          word_done,
  output logic          done,
  output logic          irq,
  output logic          bus_req,
  output logic          dev_in_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data
);
  state_e        state_q, state_d;
  logic [DW-1:0] buf_q;
  logic          done_q, irq_q;
  logic          fetch_fire, store_fire, finish_now, empty_start;

  assign fetch_fire  = (state_q == ST_FETCH) &&
                       ((dir == DIR_DEV2MEM) ? dev_in_valid : mem_ready);
  assign store_fire  = (state_q == ST_STORE) &&
                       ((dir == DIR_DEV2MEM) ? mem_ready : dev_out_ready);
  assign finish_now  = store_fire && last_word;
  assign empty_start = start && zero_len;
  assign word_done   = store_fire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start && !zero_len) state_d = ST_ASK;
      ST_ASK:   if (bus_gnt) state_d = ST_FETCH;
      ST_FETCH: if (fetch_fire) state_d = ST_STORE;
      ST_STORE: if (store_fire) begin
                  if (last_word)                state_d = ST_IDLE;
                  else if (mode == MODE_STEAL)  state_d = ST_YIELD;
                  else                          state_d = ST_FETCH;
                end
      ST_YIELD: if (!bus_gnt) state_d = ST_ASK;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      buf_q   <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fetch_fire) buf_q <= (dir == DIR_DEV2MEM) ? dev_in_data : mem_rdata;
      if (start)           done_q <= zero_len;
      else if (finish_now) done_q <= 1'b1;
      irq_q <= empty_start || finish_now;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign bus_req       = (state_q == ST_ASK) || (state_q == ST_FETCH) || (state_q == ST_STORE);
  assign dev_in_ready  = (state_q == ST_FETCH) && (dir == DIR_DEV2MEM);
  assign mem_valid     = ((state_q == ST_FETCH) && (dir == DIR_MEM2DEV)) ||
                         ((state_q == ST_STORE) && (dir == DIR_DEV2MEM));
  assign mem_we        = (state_q == ST_STORE) && (dir == DIR_DEV2MEM);
  assign mem_wdata     = buf_q;
  assign dev_out_valid = (state_q == ST_STORE) && (dir == DIR_MEM2DEV);
  assign dev_out_data  = buf_q;
  assign done          = done_q;
  assign irq           = irq_q;

  // R3
  mem_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || dev_in_ready || dev_out_valid) |-> bus_req);

  // R7
  rerequest_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && $past(state_q == ST_YIELD)) |-> !$past(bus_gnt));

  // R9
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  irq_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !bus_req));

  // R10
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_start |=> (done && !bus_req && !busy));
endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
  import xfer_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  dir_e          dir_q;
  mode_e         mode_q;
  logic          start, word_done, zero_len, last_word;

  assign zero_len  = (count_q == '0);
  assign last_word = (count_q == CW'(1));

  xfer_dma_regs #(.AW(AW), .CW(CW), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .word_done(word_done), .addr_q(addr_q), .count_q(count_q),
    .dir_q(dir_q), .mode_q(mode_q), .start(start)
  );

  xfer_dma_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_len(zero_len), .last_word(last_word),
    .dir(dir_q), .mode(mode_q), .bus_gnt(bus_gnt), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .dev_out_ready(dev_out_ready), .busy(busy), .word_done(word_done), .done(done),
    .irq(irq), .bus_req(bus_req), .dev_in_ready(dev_in_ready), .mem_valid(mem_valid),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data)
  );

  assign cur_addr  = addr_q;
  assign cur_count = count_q;
  assign mem_addr  = addr_q;
endmodule

// File: tb/xfer_dma_tb.sv
module xfer_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GNT_LAT    = 3;
  localparam int REL_LAT    = 2;
  localparam logic [31:0] SRC_BASE = 32'hA500_0000;
  localparam logic [31:0] RD_KEY   = 32'h5A5A_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cur_addr;
  logic [15:0] cur_count;
  logic busy, done, irq, bus_req;
  logic bus_gnt = 1'b0;
  logic mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;
  logic dev_in_valid = 1'b0;
  logic [31:0] dev_in_data = '0;
  logic dev_in_ready, dev_out_valid;
  logic [31:0] dev_out_data;
  logic dev_out_ready = 1'b0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit stall = 1'b0;
  int src_idx = 0, irq_cnt = 0, rise_cnt = 0;
  bit req_prev = 1'b0;
  int gnt_wait = 0, rel_wait = 0, mem_pc = 0, src_pc = 0, snk_pc = 0;
  logic [63:0] exp_mem_q[$];
  logic [31:0] exp_dev_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cur_addr(cur_addr), .cur_count(cur_count), .busy(busy), .done(done), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // arbiter, protocol monitor and watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual %0d expected below 100000", cyc);
      finish_run();
    end
    if (rst_n) begin
      // R3
      if ((mem_valid || dev_in_ready) && !bus_gnt) chk(0, "R3 bus cycle without grant", 0, 1);
      if (bus_req && !req_prev) begin
        rise_cnt++;
        // R7
        if (bus_gnt) chk(0, "R7 request raised while grant still high", 1, 0);
      end
      if (irq) irq_cnt++;
    end
    req_prev = bus_req;
    if (bus_req && !bus_gnt) begin
      gnt_wait++;
      if (gnt_wait >= GNT_LAT) begin bus_gnt = 1'b1; gnt_wait = 0; end
    end else if (!bus_req && bus_gnt) begin
      rel_wait++;
      if (rel_wait >= REL_LAT) begin bus_gnt = 1'b0; rel_wait = 0; end
    end
  end

  // memory model and write monitor
  always @(negedge clk) begin
    logic [63:0] e;
    mem_ready = !stall || (mem_pc % 3 == 2);
    mem_pc++;
    mem_rdata = mem_addr ^ RD_KEY;
    if (rst_n && mem_valid && mem_ready && mem_we) begin
      if (exp_mem_q.size() == 0) chk(0, "R4 unexpected memory write", {mem_addr, mem_wdata}, 0);
      else begin
        e = exp_mem_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R4 memory write address/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  // device source
  always @(negedge clk) begin
    dev_in_valid = !stall || (src_pc % 4 != 1);
    src_pc++;
    dev_in_data = SRC_BASE + 32'(src_idx);
    if (rst_n && dev_in_valid && dev_in_ready) src_idx++;
  end

  // device sink monitor
  always @(negedge clk) begin
    logic [31:0] e;
    dev_out_ready = !stall || (snk_pc % 2 == 0);
    snk_pc++;
    if (rst_n && dev_out_valid && dev_out_ready) begin
      if (exp_dev_q.size() == 0) chk(0, "R5 unexpected device word", dev_out_data, 0);
      else begin
        e = exp_dev_q.pop_front();
        chk(dev_out_data == e, "R5 device word", dev_out_data, e);
      end
    end
  end

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input logic [31:0] a, input int n, input bit dir, input bit mode,
                          input bit poke, input string tag);
    int base, t;
    logic [31:0] fin;
    base = src_idx;
    irq_cnt = 0;
    rise_cnt = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] wa;
      wa = a + 32'(4 * i);
      if (!dir) exp_mem_q.push_back({wa, SRC_BASE + 32'(base + i)});
      else      exp_dev_q.push_back(wa ^ RD_KEY);
    end
    write_reg(2'd0, a);
    write_reg(2'd1, 32'(n));
    write_reg(2'd2, {29'd0, 1'b1, mode, dir});
    // R9 done cleared by a new start
    chk(!done && busy, {tag, " R9 start clears done"}, {done, busy}, 2'b01);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy, {tag, " R11 busy before poke"}, busy, 1);
      write_reg(2'd2, {29'd0, 1'b1, ~mode, ~dir});
      write_reg(2'd0, 32'h9999_0000);
      write_reg(2'd1, 32'd3);
    end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    fin = a + 32'(4 * n);
    chk(t < 5000, {tag, " R9 transfer completes"}, t, 0);
    chk(done && !bus_req, {tag, " R9 done set, request released"}, {done, bus_req}, 2'b10);
    chk(irq_cnt == 1, {tag, " R9 single irq pulse"}, irq_cnt, 1);
    chk(cur_count == 0, {tag, " R8 final count"}, cur_count, 0);
    chk(cur_addr == fin, {tag, " R8/R11 final address"}, cur_addr, fin);
    if (mode) chk(rise_cnt == n, {tag, " R7 one request per word"}, rise_cnt, n);
    else      chk(rise_cnt == 1, {tag, " R6 single request for block"}, rise_cnt, 1);
    chk(exp_mem_q.size() == 0 && exp_dev_q.size() == 0, {tag, " R4/R5 all words seen"},
        exp_mem_q.size() + exp_dev_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({busy, done, irq, bus_req, mem_valid, dev_in_ready, dev_out_valid} == 7'd0,
        "R1 reset outputs", {busy, done, irq, bus_req, mem_valid, dev_in_ready, dev_out_valid}, 0);
    chk(cur_addr == 0 && cur_count == 0, "R1 reset registers", {cur_addr, 16'd0, cur_count}, 0);
    // R2
    write_reg(2'd0, 32'h0000_1230);
    write_reg(2'd1, 32'd7);
    chk(cur_addr == 32'h0000_1230, "R2 address readback", cur_addr, 32'h0000_1230);
    chk(cur_count == 16'd7, "R2 count readback", cur_count, 7);
    write_reg(2'd2, 32'h0000_0003);
    repeat (2) @(negedge clk);
    chk(!busy && !bus_req, "R2 command without go stays idle", {busy, bus_req}, 0);

    run_xfer(32'h0000_1000, 5, 1'b0, 1'b0, 1'b0, "d2m burst");
    // R10
    irq_cnt = 0; rise_cnt = 0;
    write_reg(2'd1, 32'd0);
    write_reg(2'd2, 32'h0000_0004);
    repeat (2) @(negedge clk);
    chk(done && !busy, "R10 empty start completes", {done, busy}, 2'b10);
    chk(irq_cnt == 1, "R10 irq pulse on empty start", irq_cnt, 1);
    chk(rise_cnt == 0, "R10 no bus request", rise_cnt, 0);

    stall = 1'b1;
    run_xfer(32'h0000_2000, 4, 1'b1, 1'b0, 1'b0, "m2d burst stalled");
    run_xfer(32'h0000_3000, 3, 1'b0, 1'b1, 1'b0, "d2m steal stalled");
    stall = 1'b0;
    run_xfer(32'h0000_4000, 4, 1'b1, 1'b1, 1'b0, "m2d steal");
    stall = 1'b1;
    run_xfer(32'h0000_5000, 8, 1'b0, 1'b0, 1'b1, "d2m burst with busy writes");
    stall = 1'b0;
    run_xfer(32'hFFFF_FFF8, 3, 1'b1, 1'b0, 1'b0, "m2d address wrap");
    finish_run();
  end
endmodule